// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is the interval timer that sits next to a 32-bit CPU core. It keeps a running Count register that steps by one on every cycle in which the tick-enable input is high. It also keeps a Compare register that the CPU programs with a target value. When Count steps onto the Compare value, the timer raises an interrupt request. The request is a level, and it stays up until software writes Compare again.

A 3-bit routing field chooses which of eight request lines carries the interrupt. A freeze control stops the count. A revision-2 mode flag makes the timer also keep a timer-interrupt status bit, which a match sets and a Compare write clears. Software reads both registers directly. It loads Count or Compare by pulsing the matching write strobe with the value on the shared write-data bus.

Top module: `cnt_cmp_timer`

## Requirements
- R1: After reset, Count reads 1, Compare reads 0, the status bit is 0 and all eight request lines are 0.
- R2: With freeze low, tick high and no Count write, Count increases by one on the clock edge, wrapping from 0xFFFFFFFF to 0. With tick low, Count holds.
- R3: While freeze is high, Count holds its value whatever tick does, and no match can raise the interrupt.
- R4: A Count write loads the write-data value on the next edge, whether freeze is high or low. When a tick arrives in the same cycle, the write wins, and counting resumes from the loaded value.
- R5: A Compare write loads the write-data value into Compare on the next edge.
- R6: When a step moves Count onto a value equal to Compare, the interrupt becomes pending on that edge. This includes the step from 0xFFFFFFFF to 0. Loading Count with the Compare value raises nothing. Once pending, the interrupt stays pending until a Compare write.
- R7: In revision-2 mode, a match sets the status bit. With the mode flag low, a match leaves the status bit unchanged.
- R8: A Compare write clears the pending interrupt on the next edge, and this takes priority over a match in the same cycle. In revision-2 mode the same write also clears the status bit. With the mode flag low, the status bit is kept.
- R9: The request vector is all zeros when nothing is pending. Otherwise it has a single 1, at bit index equal to the routing field (field value 0 selects bit 0). If the field changes while the interrupt is pending, the request moves to the new line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance Count by one this cycle |
| freeze | input | 1 | Hold Count and block compare matches |
| route_sel | input | 3 | Index of the request line the timer drives |
| rev2_mode | input | 1 | Enables the status-bit behaviour |
| cnt_wr | input | 1 | Load Count from wr_data |
| cmp_wr | input | 1 | Load Compare from wr_data and clear the interrupt |
| wr_data | input | 32 | Register write data |
| count_val | output | 32 | Current Count |
| compare_val | output | 32 | Current Compare |
| tmr_status | output | 1 | Timer-interrupt status bit |
| irq_lines | output | 8 | One-hot interrupt request vector |

## Verification
The hardest case to reach from the ports is the match at the top of the count range. A free-running count would need about four billion ticks to get there. The stimulus instead loads Count with 0xFFFFFFFE and Compare with 0, then ticks twice.

The random phase keeps matches frequent. It often writes Compare to a value a few ticks ahead of the bench's own Count model. It also mixes in freeze, Count writes that land on the same cycle as a tick, Compare writes that land on the same cycle as a match, changes to the routing field, and changes to the mode flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // What the Count register does on the coming edge
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_LOAD = 2'd1,
      CNT_STEP = 2'd2
   } cnt_op_e;
endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg
   import tmr_pkg::*;
#(
   parameter int          CNT_W     = 32,
   parameter logic [CNT_W-1:0] RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             freeze,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_inc,
   output logic             stepping
);
   cnt_op_e op;

   always_comb begin
      if (load)                   op = CNT_LOAD;
      else if (tick_en && !freeze) op = CNT_STEP;
      else                        op = CNT_HOLD;
   end

   assign count_inc = count_q + CNT_W'(1);
   assign stepping  = (op == CNT_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= RST_VAL;
      end else begin
         unique case (op)
            CNT_LOAD: count_q <= load_val;
            CNT_STEP: count_q <= count_inc;
            default:  count_q <= count_q;
         endcase
      end
   end
endmodule

// File: rtl/tmr_match_flag.sv
module tmr_match_flag #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stepping,
   input  logic [CNT_W-1:0] count_inc,
   input  logic [CNT_W-1:0] compare_q,
   input  logic             cmp_wr,
   input  logic             rev2_mode,
   output logic             pending,
   output logic             status
);
   logic hit;

   // Match is judged on the value Count is about to take
   assign hit = stepping && (count_inc == compare_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         status  <= 1'b0;
      end else begin
         if (cmp_wr)   pending <= 1'b0;
         else if (hit) pending <= 1'b1;

         if (rev2_mode) begin
            if (cmp_wr)   status <= 1'b0;
            else if (hit) status <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
   parameter int NUM_LINES = 8,
   parameter int SEL_W     = $clog2(NUM_LINES)
) (
   input  logic                 pending,
   input  logic [SEL_W-1:0]     sel,
   output logic [NUM_LINES-1:0] lines
);
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign lines[i] = pending && (sel == SEL_W'(i));
   end
endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer #(
   parameter int               CNT_W     = 32,
   parameter int               NUM_LINES = 8,
   parameter int               SEL_W     = $clog2(NUM_LINES),
   parameter logic [CNT_W-1:0] CNT_RST   = 1,
   parameter logic [CNT_W-1:0] CMP_RST   = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 freeze,
   input  logic [SEL_W-1:0]     route_sel,
   input  logic                 rev2_mode,
   input  logic                 cnt_wr,
   input  logic                 cmp_wr,
   input  logic [CNT_W-1:0]     wr_data,
   output logic [CNT_W-1:0]     count_val,
   output logic [CNT_W-1:0]     compare_val,
   output logic                 tmr_status,
   output logic [NUM_LINES-1:0] irq_lines
);
   localparam int LINES_POW2 = 1 << SEL_W;

   if (CNT_W < 2) begin : g_bad_width
      $error("cnt_cmp_timer: CNT_W must be at least 2");
   end
   if (NUM_LINES < 2 || LINES_POW2 != NUM_LINES) begin : g_bad_lines
      $error("cnt_cmp_timer: NUM_LINES must be a power of two, at least 2");
   end

   logic [CNT_W-1:0] count_inc;
   logic             stepping;
   logic             pending;
   logic [CNT_W-1:0] compare_q;

   tmr_count_reg #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_count (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
      .load(cnt_wr), .load_val(wr_data),
      .count_q(count_val), .count_inc(count_inc), .stepping(stepping)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      compare_q <= CMP_RST;
      else if (cmp_wr) compare_q <= wr_data;
   end
   assign compare_val = compare_q;

   tmr_match_flag #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .stepping(stepping), .count_inc(count_inc),
      .compare_q(compare_q), .cmp_wr(cmp_wr), .rev2_mode(rev2_mode),
      .pending(pending), .status(tmr_status)
   );

   tmr_irq_route #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_route (
      .pending(pending), .sel(route_sel), .lines(irq_lines)
   );
endmodule

// File: rtl/cnt_cmp_timer_chk.sv
module cnt_cmp_timer_chk #(
   parameter int CNT_W     = 32,
   parameter int NUM_LINES = 8,
   parameter int SEL_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_en,
   input logic                 freeze,
   input logic [SEL_W-1:0]     route_sel,
   input logic                 rev2_mode,
   input logic                 cnt_wr,
   input logic                 cmp_wr,
   input logic [CNT_W-1:0]     wr_data,
   input logic [CNT_W-1:0]     count_val,
   input logic [CNT_W-1:0]     compare_val,
   input logic                 tmr_status,
   input logic [NUM_LINES-1:0] irq_lines
);
   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !freeze && !cnt_wr) |=> count_val == $past(count_val) + CNT_W'(1));
   // R3
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !cnt_wr) |=> $stable(count_val));
   // R4
   count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> count_val == $past(wr_data));
   // R5
   compare_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> compare_val == $past(wr_data));
   // R7
   status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rev2_mode |=> $stable(tmr_status));
   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> irq_lines == '0);
   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr && rev2_mode) |=> !tmr_status);
   // R9
   irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_lines));
   // R9
   irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines != '0) |-> irq_lines[route_sel]);
endmodule

bind cnt_cmp_timer cnt_cmp_timer_chk #(
   .CNT_W(CNT_W), .NUM_LINES(NUM_LINES), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
   .route_sel(route_sel), .rev2_mode(rev2_mode), .cnt_wr(cnt_wr),
   .cmp_wr(cmp_wr), .wr_data(wr_data), .count_val(count_val),
   .compare_val(compare_val), .tmr_status(tmr_status), .irq_lines(irq_lines)
);

// File: tb/cnt_cmp_timer_test.sv
module cnt_cmp_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, freeze = 1'b0, rev2_mode = 1'b0;
   logic        cnt_wr = 1'b0, cmp_wr = 1'b0;
   logic [2:0]  route_sel = 3'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] count_val, compare_val;
   logic        tmr_status;
   logic [7:0]  irq_lines;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model
   logic [31:0] m_cnt, m_cmp;
   logic        m_pend, m_stat;

   always #2.5 clk = ~clk;

   cnt_cmp_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
      .route_sel(route_sel), .rev2_mode(rev2_mode), .cnt_wr(cnt_wr),
      .cmp_wr(cmp_wr), .wr_data(wr_data), .count_val(count_val),
      .compare_val(compare_val), .tmr_status(tmr_status), .irq_lines(irq_lines)
   );

   function automatic logic [7:0] exp_irq(input logic p, input logic [2:0] s);
      return p ? (8'd1 << s) : 8'd0;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2", "count", count_val, m_cnt);
      chk("R5", "compare", compare_val, m_cmp);
      chk("R7", "status", {31'd0, tmr_status}, {31'd0, m_stat});
      chk("R9", "irq", {24'd0, irq_lines}, {24'd0, exp_irq(m_pend, route_sel)});
   endtask

   // one clock with current inputs; model updated, outputs compared after edge
   task automatic step();
      logic hit;
      hit = !cnt_wr && tick_en && !freeze && (m_cnt + 32'd1 == m_cmp);
      @(posedge clk);
      #1;
      if (cnt_wr) m_cnt = wr_data;
      else if (tick_en && !freeze) m_cnt = m_cnt + 32'd1;
      if (cmp_wr) m_cmp = wr_data;
      if (cmp_wr) m_pend = 1'b0; else if (hit) m_pend = 1'b1;
      if (rev2_mode) begin
         if (cmp_wr) m_stat = 1'b0; else if (hit) m_stat = 1'b1;
      end
      check_all();
      cnt_wr = 0; cmp_wr = 0; tick_en = 0;
   endtask

   task automatic wr_count(input logic [31:0] v);
      cnt_wr = 1; wr_data = v; step();
   endtask

   task automatic wr_compare(input logic [31:0] v);
      cmp_wr = 1; wr_data = v; step();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_cnt = 32'd1; m_cmp = 32'd0; m_pend = 0; m_stat = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      // R1 reset state
      chk("R1", "count", count_val, 32'd1);
      chk("R1", "compare", compare_val, 32'd0);
      chk("R1", "status+irq", {23'd0, tmr_status, irq_lines}, 32'd0);

      // R2 plain stepping, R3 freeze
      rev2_mode = 1;
      repeat (4) begin tick_en = 1; step(); end
      chk("R2", "count after ticks", count_val, 32'd5);
      freeze = 1;
      repeat (3) begin tick_en = 1; step(); end
      chk("R3", "frozen count", count_val, 32'd5);
      // R4 load while frozen
      wr_count(32'h100);
      chk("R4", "load frozen", count_val, 32'h100);
      // R3 frozen count equal compare - no interrupt
      wr_compare(32'h101);
      tick_en = 1; step();
      chk("R3", "no irq while frozen", {24'd0, irq_lines}, 32'd0);
      freeze = 0;
      // R4 write beats tick
      tick_en = 1; cnt_wr = 1; wr_data = 32'h50; step();
      chk("R4", "write over tick", count_val, 32'h50);
      // R6 loading Count onto Compare raises nothing
      wr_count(32'h101);
      chk("R6", "load equal no irq", {24'd0, irq_lines}, 32'd0);

      // R6 wrap match, R7 status in rev2
      route_sel = 3'd5;
      wr_count(32'hFFFF_FFFE);
      wr_compare(32'h0);
      tick_en = 1; step();
      chk("R6", "no early irq", {24'd0, irq_lines}, 32'd0);
      tick_en = 1; step();
      chk("R6", "wrap irq", {24'd0, irq_lines}, 32'h20);
      chk("R7", "status set", {31'd0, tmr_status}, 32'd1);
      repeat (3) begin tick_en = 1; step(); end
      chk("R6", "irq level held", {24'd0, irq_lines}, 32'h20);
      // R9 route change moves request
      route_sel = 3'd0; #1;
      chk("R9", "moved to line 0", {24'd0, irq_lines}, 32'h01);
      // R8 compare write clears in rev2
      wr_compare(32'h40);
      chk("R8", "irq cleared", {24'd0, irq_lines}, 32'd0);
      chk("R8", "status cleared", {31'd0, tmr_status}, 32'd0);

      // R7/R8 non-rev2: status untouched by match and by compare write
      rev2_mode = 0;
      wr_count(32'h3F);
      tick_en = 1; step();
      chk("R7", "match w/o rev2 irq", {24'd0, irq_lines}, 32'h01);
      chk("R7", "status untouched", {31'd0, tmr_status}, 32'd0);
      rev2_mode = 1;
      wr_count(32'h3F);
      wr_compare(32'h40);
      tick_en = 1; step();
      chk("R7", "status set rev2", {31'd0, tmr_status}, 32'd1);
      rev2_mode = 0;
      wr_compare(32'h1000);
      chk("R8", "status kept w/o rev2", {31'd0, tmr_status}, 32'd1);
      chk("R8", "irq cleared w/o rev2", {24'd0, irq_lines}, 32'd0);

      // R8 compare write in the same cycle as a match wins
      rev2_mode = 1;
      wr_count(32'hFFF);
      tick_en = 1; cmp_wr = 1; wr_data = 32'h2000; step();
      chk("R8", "clear beats match", {24'd0, irq_lines}, 32'd0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         tick_en = ($urandom_range(0, 3) != 0);
         freeze  = ($urandom_range(0, 7) == 0);
         if ($urandom_range(0, 15) == 0) route_sel = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 63) == 0) rev2_mode = ~rev2_mode;
         if (r < 4) begin
            cnt_wr = 1; wr_data = $urandom;
         end else if (r < 12) begin
            cmp_wr = 1; wr_data = m_cnt + 32'($urandom_range(0, 12));
         end
         step();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule